// File: doc/BRIEF.md
# Scaler with Tapped One-Shot Pulses

This block is a free-running scaler: a wide binary counter that steps once per clock whenever its enable input is high and keeps its value otherwise. Three taps watch stages of the counter. Each tap drives a three-state one-shot that emits a single-cycle pulse when its stage goes high. It will not fire again until it has seen that stage go low.

Two taps watch plain counter bits, a fast one and a slow one. The third tap, the decade tap, watches a bit of the count divided by ten. With a 1.024 MHz scaler clock it gives a 10 ms tick. Every decade pulse is copied onto a group of timer-increment strobes, which feed timer counters outside this block.

Top module: `tick_scaler`

## Requirements
- R1: A synchronous reset clears the counter to zero and returns every one-shot to its idle state. While reset is held and on the first sample after it, all pulses and all timer strobes are low.
- R2: The counter advances by exactly one on each clock edge at which `enable` is high and reset is low. On every other edge it holds its value. Because the taps are derived from the count, holding the count shifts every later pulse by the number of cycles it was held.
- R3: The fast tap watches counter bit index 12 (LSB is index 0). `pulse_fast` is high in the cycle after the first clock edge at which that bit is seen as 1.
- R4: The slow tap watches counter bit index 16. `pulse_slow` follows the same rule as in R3, applied to that bit.
- R5: The decade tap watches bit index 9 of floor(count / 10), computed in the same cycle as the count. `pulse_dec` follows the same rule as in R3, applied to that value.
- R6: A pulse lasts exactly one clock cycle. It is never high in two consecutive cycles.
- R7: After a pulse, a one-shot does not pulse again while its watched stage stays 1, however long that lasts. It re-arms only after one clock edge at which the stage is seen as 0.
- R8: All bits of `timer_inc` are high in exactly the cycles in which `pulse_dec` is high, and low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scaler clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Counter advances while high |
| pulse_fast | output | 1 | One-cycle pulse from the fast tap |
| pulse_slow | output | 1 | One-cycle pulse from the slow tap |
| pulse_dec | output | 1 | One-cycle pulse from the decade tap |
| timer_inc | output | N_TIMERS | Increment strobes for the external timers (3 by default) |

## Verification
The bench drives `enable` in three patterns: held low, held high, and toggled every cycle. With `enable` held low there must be no pulses at all. With `enable` held high the pulses fall at the computed count boundaries. With `enable` toggling, every pulse moves to twice the cycle distance, which shows that the counter steps only on enabled edges. `enable` is also dropped while the fast tap's bit is high, to show that a stage held high for hundreds of cycles yields one pulse and no more. A long enabled run carries the count past the slow tap's boundary and through many decade boundaries. During that run the decade pulse train and the timer strobes are checked against each other, cycle by cycle.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
   typedef enum logic [1:0] {
      OS_ARMED = 2'd0,
      OS_FIRE  = 2'd1,
      OS_HOLD  = 2'd2,
      OS_BAD   = 2'd3
   } oneshot_state_e;

   localparam int unsigned NUM_TAPS = 3;
   localparam int unsigned TAP_FAST = 0;
   localparam int unsigned TAP_SLOW = 1;
   localparam int unsigned TAP_DEC  = 2;
endpackage

// File: rtl/scaler_count.sv
module scaler_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (enable)
         count <= count + 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      enable |=> count == $past(count) + 1'b1);  // R2
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !enable |=> $stable(count));  // R2
endmodule

// File: rtl/scaler_tap.sv
module scaler_tap #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned DIVISOR = 1,
   parameter int unsigned BIT_IDX = 0
) (
   input  logic [CNT_W-1:0] count,
   output logic             stage
);
   if (DIVISOR == 0) begin : g_bad_div
      $error("scaler_tap: DIVISOR must be nonzero");
   end
   if (BIT_IDX >= CNT_W) begin : g_bad_bit
      $error("scaler_tap: BIT_IDX outside counter");
   end

   if (DIVISOR == 1) begin : g_direct
      assign stage = count[BIT_IDX];
   end else begin : g_divided
      localparam logic [CNT_W-1:0] DIV_V = CNT_W'(DIVISOR);
      logic [CNT_W-1:0] quot;
      assign quot  = count / DIV_V;
      assign stage = quot[BIT_IDX];
   end
endmodule

// File: rtl/scaler_oneshot.sv
module scaler_oneshot
   import scaler_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic stage,
   output logic pulse
);
   oneshot_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         OS_ARMED: if (stage)  state_d = OS_FIRE;
         OS_FIRE:              state_d = OS_HOLD;
         OS_HOLD:  if (!stage) state_d = OS_ARMED;
         default:              state_d = OS_ARMED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= OS_ARMED;
      else     state_q <= state_d;
   end

   // The low bit of the state encoding is the pulse.
   assign pulse = state_q[0];

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !pulse);  // R6
   AST_FIRE_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (state_q == OS_ARMED && !stage) |=> !pulse);  // R3
   AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
      (state_q == OS_HOLD && stage) |=> !pulse);  // R7
   AST_NO_BAD: assert property (@(posedge clk) disable iff (rst)
      state_q != OS_BAD);  // R1
endmodule

// File: rtl/tick_scaler.sv
module tick_scaler
   import scaler_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned FAST_BIT = 12,
   parameter int unsigned SLOW_BIT = 16,
   parameter int unsigned DEC_DIV  = 10,
   parameter int unsigned DEC_BIT  = 9,
   parameter int unsigned N_TIMERS = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                enable,
   output logic                pulse_fast,
   output logic                pulse_slow,
   output logic                pulse_dec,
   output logic [N_TIMERS-1:0] timer_inc
);
   if (N_TIMERS == 0) begin : g_bad_timers
      $error("tick_scaler: N_TIMERS must be nonzero");
   end

   function automatic int unsigned tap_bit(int unsigned i);
      if (i == TAP_FAST) return FAST_BIT;
      if (i == TAP_SLOW) return SLOW_BIT;
      return DEC_BIT;
   endfunction

   function automatic int unsigned tap_div(int unsigned i);
      return (i == TAP_DEC) ? DEC_DIV : 1;
   endfunction

   logic [CNT_W-1:0]    count;
   logic [NUM_TAPS-1:0] stage;
   logic [NUM_TAPS-1:0] pulse;

   scaler_count #(.CNT_W(CNT_W)) i_count (
      .clk(clk), .rst(rst), .enable(enable), .count(count)
   );

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      scaler_tap #(
         .CNT_W(CNT_W), .DIVISOR(tap_div(t)), .BIT_IDX(tap_bit(t))
      ) i_tap (
         .count(count), .stage(stage[t])
      );
      scaler_oneshot i_shot (
         .clk(clk), .rst(rst), .stage(stage[t]), .pulse(pulse[t])
      );
   end

   assign pulse_fast = pulse[TAP_FAST];
   assign pulse_slow = pulse[TAP_SLOW];
   assign pulse_dec  = pulse[TAP_DEC];
   assign timer_inc  = {N_TIMERS{pulse[TAP_DEC]}};

   AST_STROBE_ON_DEC: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_dec) |-> (&timer_inc));  // R8
endmodule

// File: tb/test_tick_scaler.sv
module test_tick_scaler;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic enable = 1'b0;
   logic pulse_fast, pulse_slow, pulse_dec;
   logic [2:0] timer_inc;

   always #5 clk = ~clk;

   tick_scaler i_tick_scaler (
      .clk(clk), .rst(rst), .enable(enable),
      .pulse_fast(pulse_fast), .pulse_slow(pulse_slow),
      .pulse_dec(pulse_dec), .timer_inc(timer_inc)
   );

   int tests = 0;
   int fails = 0;

   // Bench model: the count and the tap value seen at the previous edge
   longint mc;
   bit pf, ps, pd;
   bit ef, es, ed;
   int mm_f, mm_s, mm_d, mm_w, mm_t;
   int nf_d, ns_d, nd_d, nf_m, ns_m, nd_m;
   bit last_f, last_s, last_d;

   function automatic bit tap_f(longint c); return ((c >> 12) & 1) != 0; endfunction
   function automatic bit tap_s(longint c); return ((c >> 16) & 1) != 0; endfunction
   function automatic bit tap_d(longint c); return (((c / 10) >> 9) & 1) != 0; endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_stats();
      mm_f = 0; mm_s = 0; mm_d = 0; mm_w = 0; mm_t = 0;
      nf_d = 0; ns_d = 0; nd_d = 0; nf_m = 0; ns_m = 0; nd_m = 0;
   endtask

   // mode 0: enable low, 1: enable high, 2: enable toggles each cycle
   task automatic run_cycles(int n, int mode);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pulse_fast !== ef) mm_f++;
         if (pulse_slow !== es) mm_s++;
         if (pulse_dec  !== ed) mm_d++;
         if (timer_inc !== {3{ed}}) mm_t++;
         if ((pulse_fast && last_f) || (pulse_slow && last_s) || (pulse_dec && last_d)) mm_w++;
         last_f = pulse_fast; last_s = pulse_slow; last_d = pulse_dec;
         nf_d += int'(pulse_fast); ns_d += int'(pulse_slow); nd_d += int'(pulse_dec);
         enable = (mode == 1) || (mode == 2 && (i % 2 == 0));
         @(posedge clk);
         ef = tap_f(mc) && !pf; pf = tap_f(mc);
         es = tap_s(mc) && !ps; ps = tap_s(mc);
         ed = tap_d(mc) && !pd; pd = tap_d(mc);
         nf_m += int'(ef); ns_m += int'(es); nd_m += int'(ed);
         if (enable) mc++;
      end
   endtask

   task automatic t_reset();
      rst = 1'b1; enable = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!pulse_fast && !pulse_slow && !pulse_dec, "R1 pulses in reset",
            {pulse_fast, pulse_slow, pulse_dec}, 0);
      check(timer_inc == 3'b000, "R1 strobes in reset", timer_inc, 0);
      rst = 1'b0; enable = 1'b0;
      mc = 0; pf = 0; ps = 0; pd = 0; ef = 0; es = 0; ed = 0;
      last_f = 0; last_s = 0; last_d = 0;
   endtask

   task automatic t_idle();
      clear_stats();
      run_cycles(300, 0);
      check(nf_d + ns_d + nd_d == 0, "R2 no pulses while disabled", nf_d + ns_d + nd_d, 0);
   endtask

   task automatic t_first_fast();
      clear_stats();
      run_cycles(4200, 1);
      check(mm_f == 0, "R3 fast pulse timing", mm_f, 0);
      check(nf_d == 1, "R3 one fast pulse by count 4200", nf_d, 1);
      check(nd_d == 0 && ns_d == 0, "R5 no slow/decade pulse yet", nd_d + ns_d, 0);
   endtask

   task automatic t_hold_high();
      clear_stats();
      run_cycles(500, 0);
      check(nf_d == 0, "R7 no refire while stage held high", nf_d, 0);
   endtask

   task automatic t_toggle();
      clear_stats();
      run_cycles(6000, 2);
      check(mm_f == 0 && mm_d == 0 && mm_s == 0, "R2 half-rate stepping", mm_f + mm_d + mm_s, 0);
      check(nd_d == 1, "R5 decade pulse at count 5120", nd_d, 1);
   endtask

   task automatic t_long_run();
      clear_stats();
      run_cycles(130000, 1);
      check(mm_s == 0 && ns_d == 1, "R4 slow pulse at count 65536", ns_d, 1);
      check(mm_d == 0 && nd_d == nd_m, "R5 decade pulse train", nd_d, nd_m);
      check(nd_d == 12, "R5 decade pulse count", nd_d, 12);
      check(mm_f == 0 && nf_d == 16, "R3 fast pulse count", nf_d, 16);
      check(mm_w == 0, "R6 single-cycle pulses", mm_w, 0);
      check(mm_t == 0, "R8 timer strobes track decade pulse", mm_t, 0);
      check(nf_d == nf_m, "R7 no extra fast pulses", nf_d, nf_m);
   endtask

   bit done = 0;
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_idle();
      t_first_fast();
      t_hold_high();
      t_toggle();
      t_long_run();
      t_reset();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule